// File: doc/BRIEF.md
# Carry-Out Vector Generation Unit

This unit takes two 64-bit source operands, an add/subtract select and an operand size of 8, 16, 32 or 64 bits. It does not return the sum or the difference. It returns the per-bit carry-out vector of the selected operation. Bit i of that vector is the carry leaving bit position i. Software or a later stage can read every flag from this vector, and it can do so long after the arithmetic that produced it. It can also use the vector to find which lanes of a packed operation overflowed.

For sizes narrower than 64 bits, the carry vector of the narrow width is repeated upward until all 64 output bits are filled. The result is that the flag information always sits in the same places:
- Bit 63 holds the carry flag.
- Bit 63 XOR bit 62 gives signed overflow.
- Bit 3 holds the carry out of the low nibble.

Operands are captured when `in_valid` is high. The result appears on a registered output one clock later, marked by `out_valid`.

Top module: `cov_unit`

## Requirements
- R1: With `op_sub`=0, `carry_vec` bit i equals the carry out of bit position i of `src_a + src_b`, taken over the selected width, with a carry-in of 0.
- R2: With `op_sub`=1, the vector is the carry-out vector of `src_a + ~src_b + 1`. The injected 1 enters at bit 0, so bit 63 reads 1 when no borrow occurs.
- R3: `op_size` encodes the width as 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. For a width W below 64, output bit j equals the narrow carry bit at position j mod W.
- R4: Source bits at or above the selected width have no effect on the output.
- R5: `carry_vec[63]` equals the carry out of the most significant bit of the selected width.
- R6: `carry_vec[63]` XOR `carry_vec[62]` equals the two's-complement signed overflow of the selected operation at the selected width.
- R7: `carry_vec[3]` equals the carry out of operand bits [3:0], including the bit-0 carry-in.
- R8: `out_valid` is high in the cycle after a clock edge that samples `in_valid`=1 and low otherwise. `carry_vec` changes only on a clock edge that samples `in_valid`=1.
- R9: A synchronous active-high `rst` clears `carry_vec` to zero and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture strobe for the operands and controls |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| op_size | input | 2 | Operand width select (0: 8, 1: 16, 2: 32, 3: 64) |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| out_valid | output | 1 | Result valid, one cycle after capture |
| carry_vec | output | 64 | Replicated carry-out vector |

## Verification
The hardest case to reach is a carry chain that crosses the boundary of a narrow width while the upper source bits are full of noise. The narrow result must still ignore those bits and repeat cleanly. Random operands seldom produce long carry runs, so the bench adds directed operands at the extremes: all ones plus one, the signed maximum plus one, and equal operands under subtraction. It also replays narrow cases with the upper bits both cleared and randomly filled. Uniform random sizes and operations then cover the mixture of both.

// File: rtl/cov_pkg.sv
package cov_pkg;
  localparam int CV_W     = 64;
  localparam int NUM_SIZE = 4;                 // 8,16,32,64
  localparam int SIZE_W   = $clog2(NUM_SIZE);

  typedef logic [CV_W-1:0] word_t;

  function automatic int size_bits(input logic [SIZE_W-1:0] sz);
    return 8 << sz;
  endfunction

  function automatic word_t lane_mask(input logic [SIZE_W-1:0] sz);
    int w;
    w = size_bits(sz);
    if (w >= CV_W) return '1;
    return (word_t'(1) << w) - word_t'(1);
  endfunction

  // carry leaving the top bit of the selected width, by widened addition
  function automatic logic width_carry(input word_t a, input word_t b,
                                       input logic cin, input logic [SIZE_W-1:0] sz);
    logic [CV_W:0] t;
    t = {1'b0, a} + {1'b0, b} + {{CV_W{1'b0}}, cin};
    return t[size_bits(sz)];
  endfunction

  // signed overflow by the operand/result sign rule
  function automatic logic width_overflow(input word_t a, input word_t b,
                                          input logic cin, input logic [SIZE_W-1:0] sz);
    word_t t;
    int    m;
    t = a + b + word_t'(cin);
    m = size_bits(sz) - 1;
    return (a[m] == b[m]) && (t[m] != a[m]);
  endfunction
endpackage

// File: rtl/cov_operand_prep.sv
module cov_operand_prep
  import cov_pkg::*;
(
  input  word_t             src_a,
  input  word_t             src_b,
  input  logic              op_sub,
  input  logic [SIZE_W-1:0] op_size,
  output word_t             pa,
  output word_t             pb,
  output logic              cin
);
  word_t mask;

  always_comb begin
    mask = lane_mask(op_size);
    pa   = src_a & mask;
    pb   = (op_sub ? ~src_b : src_b) & mask;
    cin  = op_sub;
  end
endmodule

// File: rtl/cov_carry_chain.sv
module cov_carry_chain
  import cov_pkg::*;
(
  input  word_t pa,
  input  word_t pb,
  input  logic  cin,
  output word_t sum,
  output word_t nvec
);
  logic [CV_W:0] full;

  always_comb begin
    full = {1'b0, pa} + {1'b0, pb} + {{CV_W{1'b0}}, cin};
    sum  = full[CV_W-1:0];
    // carry into bit i+1 is carry out of bit i
    nvec = full[CV_W:1] ^ {1'b0, pa[CV_W-1:1]} ^ {1'b0, pb[CV_W-1:1]};
  end
endmodule

// File: rtl/cov_replicate.sv
module cov_replicate
  import cov_pkg::*;
(
  input  word_t             nvec,
  input  logic [SIZE_W-1:0] op_size,
  output word_t             rvec
);
  logic [NUM_SIZE-1:0][CV_W-1:0] reps;

  for (genvar k = 0; k < NUM_SIZE; k++) begin : g_size
    localparam int W = 8 << k;
    for (genvar j = 0; j < CV_W; j++) begin : g_bit
      assign reps[k][j] = nvec[j % W];
    end
  end

  assign rvec = reps[op_size];
endmodule

// File: rtl/cov_unit.sv
module cov_unit
  import cov_pkg::*;
#(
  parameter int DATA_W = CV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic [SIZE_W-1:0] op_size,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] carry_vec
);
  word_t pa, pb, sum, nvec, rvec;
  logic  cin;

  cov_operand_prep u_prep (
    .src_a(src_a), .src_b(src_b), .op_sub(op_sub), .op_size(op_size),
    .pa(pa), .pb(pb), .cin(cin)
  );

  cov_carry_chain u_chain (
    .pa(pa), .pb(pb), .cin(cin), .sum(sum), .nvec(nvec)
  );

  cov_replicate u_rep (
    .nvec(nvec), .op_size(op_size), .rvec(rvec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      carry_vec <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) carry_vec <= rvec;
    end
  end

  // independent event wires for the checks below
  logic flag_c, flag_v, nib_carry;
  assign flag_c    = width_carry(pa, pb, cin, op_size);
  assign flag_v    = width_overflow(pa, pb, cin, op_size);
  assign nib_carry = ({1'b0, pa[3:0]} + {1'b0, pb[3:0]} + {4'd0, cin}) > 5'd15;

  AST_COUT_FORM: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (nvec == ((pa & pb) | ((pa | pb) & ~sum)))); // R1
  AST_REPL_8:    assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_size == 2'd0) |=> (carry_vec[63:8] == {7{carry_vec[7:0]}})); // R3
  AST_REPL_16:   assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_size == 2'd1) |=> (carry_vec[63:16] == {3{carry_vec[15:0]}})); // R3
  AST_REPL_32:   assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_size == 2'd2) |=> (carry_vec[63:32] == carry_vec[31:0])); // R3
  AST_CARRY_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (carry_vec[63] == $past(flag_c))); // R5
  AST_OVF_FLAG:  assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((carry_vec[63] ^ carry_vec[62]) == $past(flag_v))); // R6
  AST_NIBBLE:    assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (carry_vec[3] == $past(nib_carry))); // R7
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8
  AST_VALID_LOW: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R8
  AST_HOLD:      assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(carry_vec)); // R8
  AST_RESET:     assert property (@(posedge clk)
    rst |=> (!out_valid && carry_vec == '0)); // R9
endmodule

// File: tb/cov_unit_tb.sv
module cov_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        op_sub;
  logic [1:0]  op_size;
  logic [63:0] src_a, src_b;
  logic        out_valid;
  logic [63:0] carry_vec;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cov_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub), .op_size(op_size),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .carry_vec(carry_vec)
  );

  // bit-serial ripple reference, then replication by modulo
  function automatic logic [63:0] ref_vec(input logic [63:0] a, input logic [63:0] b,
                                          input logic sub, input logic [1:0] sz);
    int w;
    logic c, bb;
    logic [63:0] nar, r;
    w = 8 << sz;
    c = sub;
    nar = '0;
    for (int i = 0; i < w; i++) begin
      bb = sub ? ~b[i] : b[i];
      nar[i] = (a[i] & bb) | (c & (a[i] ^ bb));
      c = nar[i];
    end
    for (int j = 0; j < 64; j++) r[j] = nar[j % w];
    return r;
  endfunction

  function automatic logic [63:0] trunc(input logic [63:0] v, input logic [1:0] sz);
    int w;
    w = 8 << sz;
    return (w == 64) ? v : (v & ((64'd1 << w) - 64'd1));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue one operation, check vector and flag bits one cycle later
  task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                        input logic sub, input logic [1:0] sz);
    logic [63:0] exp, ma, mb, res;
    logic        cf, vf, nf;
    int          w;
    w   = 8 << sz;
    exp = ref_vec(a, b, sub, sz);
    ma  = trunc(a, sz);
    mb  = trunc(sub ? ~b : b, sz);
    res = ma + mb + 64'(sub);
    cf  = (w == 64) ? ((({1'b0, ma} + {1'b0, mb} + 65'(sub)) >> 64) != 0) : res[w];
    vf  = (ma[w-1] == mb[w-1]) && (res[w-1] != ma[w-1]);
    nf  = ((ma[3:0] + mb[3:0] + 5'(sub)) >> 4) != 0;
    @(negedge clk);
    in_valid = 1'b1; src_a = a; src_b = b; op_sub = sub; op_size = sz;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R8 out_valid after strobe", 64'(out_valid), 64'd1);
    chk(carry_vec == exp, sub ? "R2 sub vector" : "R1 add vector", carry_vec, exp);
    if (sz != 2'd3) chk(carry_vec == exp, "R3 replication", carry_vec, exp);
    chk(carry_vec[63] == cf, "R5 carry flag", 64'(carry_vec[63]), 64'(cf));
    chk((carry_vec[63] ^ carry_vec[62]) == vf, "R6 overflow flag",
        64'(carry_vec[63] ^ carry_vec[62]), 64'(vf));
    chk(carry_vec[3] == nf, "R7 nibble carry", 64'(carry_vec[3]), 64'(nf));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'h5eed_c0de));
    rst = 1'b1; in_valid = 1'b0; op_sub = 1'b0; op_size = 2'd3;
    src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset out_valid", 64'(out_valid), 64'd0);
    chk(carry_vec == '0, "R9 reset vector", carry_vec, 64'd0);
    rst = 1'b0;

    // directed corners
    run_op(64'h7F, 64'h01, 1'b0, 2'd0);                 // signed max + 1
    run_op(64'hA0, 64'hA0, 1'b0, 2'd0);                 // both overflows
    run_op('1, 64'd1, 1'b0, 2'd3);                      // full 64-bit ripple
    run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 2'd3);
    run_op(64'h1234, 64'h1234, 1'b1, 2'd1);             // equal sub, no borrow
    run_op(64'd0, 64'd1, 1'b1, 2'd2);                   // borrow
    run_op(64'h8000_0000, 64'd1, 1'b1, 2'd2);           // signed min - 1
    run_op(64'h0F, 64'h01, 1'b0, 2'd0);                 // nibble carry only

    // R4: upper noise must not change narrow results
    for (int k = 0; k < 3; k++) begin
      logic [63:0] a, b, clean;
      logic [1:0]  sz;
      sz = 2'(k);
      a  = {$urandom, $urandom};
      b  = {$urandom, $urandom};
      clean = ref_vec(trunc(a, sz), trunc(b, sz), 1'b1, sz);
      @(negedge clk);
      in_valid = 1'b1; src_a = a; src_b = b; op_sub = 1'b1; op_size = sz;
      @(negedge clk);
      in_valid = 1'b0;
      chk(carry_vec == clean, "R4 upper bits ignored", carry_vec, clean);
    end

    // R8: hold and valid drop with noisy idle inputs
    held = carry_vec;
    @(negedge clk);
    src_a = '1; src_b = 64'h5; op_sub = 1'b0; op_size = 2'd3;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid idle", 64'(out_valid), 64'd0);
    chk(carry_vec == held, "R8 hold without strobe", carry_vec, held);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (n % 4 == 1) b = ~a;
      if (n % 4 == 2) b = a;
      run_op(a, b, 1'($urandom), 2'($urandom));
    end

    // R9: reset after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R9 reset out_valid late", 64'(out_valid), 64'd0);
    chk(carry_vec == '0, "R9 reset vector late", carry_vec, 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule